// File: doc/BRIEF.md
# Vector Length Configuration Unit

This unit carries out the vector configure instruction whose vtype comes from an immediate. It watches an offered 32-bit instruction word. When the word matches the configure encoding, the unit takes the requested application vector length (AVL) from the value of the scalar source register. It decodes the 11-bit vtype immediate and grants a vector length against a vector register width of 128 bits. It then updates its own vl and vtype state registers.

The granted length must also reach the scalar destination register. One register-file write port cannot take both results in the same step, so the work runs over three named states:

- **IDLE** waits for an instruction. It moves to COMMIT when `in_valid` is high and the word matches. Any other word leaves it in IDLE.
- **COMMIT** loads the vl/vtype state on its closing edge and then moves to WRBACK.
- **WRBACK** presents the write to rd together with a one-cycle `done` pulse, then moves back to IDLE.

`in_ready` is high only in IDLE. Downstream vector logic reads the current vl, vtype, element-width code and illegal-configuration flag at all times.

Top module: `vcfg_unit`

## Requirements
- R1: A word is accepted only in IDLE with `in_valid` high and a matching encoding: bits [6:0] = 1010111, bits [14:12] = 111 and bit 31 = 0. Any other word changes neither vl nor vtype, and raises neither `done` nor `rd_we`.
- R2: Take the edge on which a word is accepted. `in_ready` is low for the next two cycles. On the following edge vl/vtype take their new values. In the cycle after that edge, `done` and `rd_we` are both high. The unit then returns to IDLE with `in_ready` high.
- R3: For a legal immediate (bits [10:0] = instr[30:20]), `vtype_o` is assembled as follows. Bits [2:0] hold the grouping code: 000=1, 001=2, 010=4, 011=8, 101=1/8, 110=1/4, 111=1/2. Bits [5:3] hold the element-width code: 000=8, 001=16, 010=32, 011=64 bits. Bit 6 holds tail-agnostic and bit 7 holds mask-agnostic. Bits [31:8] are zero.
- R4: VLMAX = LMUL × 128 / SEW. The granted vl is AVL when AVL ≤ VLMAX and VLMAX otherwise. For example, e8 with grouping 8 gives 128 elements.
- R5: The configuration is illegal if any of these holds: the element-width code is 1xx, the grouping code is 100, immediate bits [10:8] are nonzero, or a fractional grouping makes VLMAX less than 1. An illegal configuration sets `vtype_o` to 0x80000000 (illegal flag in bit 31, every other bit 0), sets vl to 0 and writes 0 to rd.
- R6: After reset, vl = 0, `vtype_o` = 0x80000000, `done` = 0, `rd_we` = 0 and `in_ready` = 1.
- R7: `sew_o` equals `vtype_o[5:3]`, and `vill_o` equals `vtype_o[31]`.
- R8: In the `done` cycle, `rd_addr` equals instr[11:7] of the accepted word and `rd_data` equals the new vl, zero-extended. `done` lasts exactly one cycle per accepted word.
- R9: The AVL is sampled on the accepting edge, and later changes to `rs1_val` have no effect. An AVL of 0 with a legal vtype gives vl = 0 with `vill_o` = 0.
- R10: `rs1_addr` always shows instr[19:15], so the register file can supply `rs1_val`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | An instruction word is offered |
| in_ready | output | 1 | Unit is in IDLE and can accept a word |
| instr | input | 32 | Instruction word |
| rs1_addr | output | 5 | Index of the AVL source register |
| rs1_val | input | 32 | AVL value read from the scalar register file |
| rd_we | output | 1 | Write enable for scalar rd |
| rd_addr | output | 5 | Scalar destination index |
| rd_data | output | 32 | New vl, zero-extended |
| done | output | 1 | One-cycle completion pulse |
| vl_o | output | 8 | Current vector length |
| vtype_o | output | 32 | Current vtype |
| sew_o | output | 3 | Current element-width code |
| vill_o | output | 1 | Current configuration is illegal |

## Verification
The assertions assume that `instr` and `in_valid` change only between clock edges. They also assume that `rs1_val` is valid on the accepting edge. The bench meets both conditions by driving every input on the falling edge.

The assertions also assume that nothing resets the unit between an accept and its `done`. The bench asserts reset only at the start of the run.

Words offered while the unit is busy are allowed and must be ignored. The bench offers such words on purpose, and always withdraws them before the unit is back in IDLE. This keeps every accept intended.

// File: rtl/vcfg_pkg.sv
package vcfg_pkg;
    typedef enum logic [1:0] {
        S_IDLE   = 2'd0,
        S_COMMIT = 2'd1,
        S_WRBACK = 2'd2
    } cfg_state_e;

    typedef struct packed {
        logic       ma;
        logic       ta;
        logic [2:0] sew;
        logic [2:0] lmul;
    } vtype_fields_t;

    localparam logic [6:0] OPC_VCFG = 7'b1010111;
    localparam logic [2:0] F3_VCFG  = 3'b111;
endpackage

// File: rtl/vcfg_decode.sv
module vcfg_decode
    import vcfg_pkg::*;
(
    input  logic [31:0] instr,
    output logic        is_vcfg,
    output logic [10:0] imm,
    output logic [4:0]  rs1_idx,
    output logic [4:0]  rd_idx
);
    always_comb begin
        is_vcfg = (instr[6:0] == OPC_VCFG) && (instr[14:12] == F3_VCFG) && !instr[31];
        imm     = instr[30:20];
        rs1_idx = instr[19:15];
        rd_idx  = instr[11:7];
    end
endmodule

// File: rtl/vtype_check.sv
module vtype_check
    import vcfg_pkg::*;
#(
    parameter int VLEN = 128,
    localparam int LOGV = $clog2(VLEN),
    localparam int VL_W = LOGV + 1
) (
    input  logic [10:0]     imm,
    output logic            vill,
    output vtype_fields_t   fields,
    output logic [VL_W-1:0] vlmax
);
    logic              fmt_bad;
    logic signed [7:0] lmul_log;
    logic signed [7:0] exp_s;

    always_comb begin
        fmt_bad  = 1'b0;
        lmul_log = 8'sd0;
        unique case (imm[2:0])
            3'b000: lmul_log = 8'sd0;
            3'b001: lmul_log = 8'sd1;
            3'b010: lmul_log = 8'sd2;
            3'b011: lmul_log = 8'sd3;
            3'b101: lmul_log = -8'sd3;
            3'b110: lmul_log = -8'sd2;
            3'b111: lmul_log = -8'sd1;
            default: fmt_bad = 1'b1;
        endcase
        if (imm[5] || (imm[10:8] != 3'b000)) fmt_bad = 1'b1;
        exp_s = 8'(LOGV) + lmul_log - 8'sd3 - $signed({5'b0, imm[5:3]});
        vill  = fmt_bad || exp_s[7];
        if (vill) begin
            fields = '0;
            vlmax  = '0;
        end else begin
            fields = vtype_fields_t'(imm[7:0]);
            vlmax  = VL_W'(1) << exp_s[3:0];
        end
    end
endmodule

// File: rtl/vl_calc.sv
module vl_calc #(
    parameter int XLEN = 32,
    parameter int VL_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [XLEN-1:0] avl,
    input  logic [VL_W-1:0] vlmax,
    input  logic            vill,
    output logic [VL_W-1:0] vl
);
    always_comb begin
        if (vill)
            vl = '0;
        else if (avl <= XLEN'(vlmax))
            vl = avl[VL_W-1:0];
        else
            vl = vlmax;
    end

    // R4: granted length never exceeds VLMAX and is AVL or VLMAX
    a_r4_vl_bound: assert property (@(posedge clk) disable iff (!rst_n)
        !vill |-> (vl <= vlmax) && ((vl == vlmax) || (XLEN'(vl) == avl)));
endmodule

// File: rtl/vcfg_unit.sv
module vcfg_unit
    import vcfg_pkg::*;
#(
    parameter int XLEN = 32,
    parameter int VLEN = 128,
    localparam int VL_W = $clog2(VLEN) + 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            in_valid,
    output logic            in_ready,
    input  logic [31:0]     instr,
    output logic [4:0]      rs1_addr,
    input  logic [XLEN-1:0] rs1_val,
    output logic            rd_we,
    output logic [4:0]      rd_addr,
    output logic [XLEN-1:0] rd_data,
    output logic            done,
    output logic [VL_W-1:0] vl_o,
    output logic [XLEN-1:0] vtype_o,
    output logic [2:0]      sew_o,
    output logic            vill_o
);
    cfg_state_e      state_q, state_d;
    logic            is_vcfg;
    logic [10:0]     dec_imm;
    logic [4:0]      dec_rd;
    logic            accept;
    logic [10:0]     imm_q;
    logic [4:0]      rd_q;
    logic [XLEN-1:0] avl_q;
    logic            chk_vill;
    vtype_fields_t   chk_fields;
    logic [VL_W-1:0] chk_vlmax;
    logic [VL_W-1:0] new_vl;
    logic [VL_W-1:0] vl_q;
    logic            vill_q;
    vtype_fields_t   fields_q;

    vcfg_decode u_dec (
        .instr   (instr),
        .is_vcfg (is_vcfg),
        .imm     (dec_imm),
        .rs1_idx (rs1_addr),
        .rd_idx  (dec_rd)
    );

    vtype_check #(.VLEN(VLEN)) u_chk (
        .imm    (imm_q),
        .vill   (chk_vill),
        .fields (chk_fields),
        .vlmax  (chk_vlmax)
    );

    vl_calc #(.XLEN(XLEN), .VL_W(VL_W)) u_vl (
        .clk   (clk),
        .rst_n (rst_n),
        .avl   (avl_q),
        .vlmax (chk_vlmax),
        .vill  (chk_vill),
        .vl    (new_vl)
    );

    assign accept = (state_q == S_IDLE) && in_valid && is_vcfg;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:   if (accept) state_d = S_COMMIT;
            S_COMMIT: state_d = S_WRBACK;
            S_WRBACK: state_d = S_IDLE;
            default:  state_d = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            imm_q    <= '0;
            rd_q     <= '0;
            avl_q    <= '0;
            vl_q     <= '0;
            vill_q   <= 1'b1;
            fields_q <= '0;
        end else begin
            if (accept) begin
                imm_q <= dec_imm;
                rd_q  <= dec_rd;
                avl_q <= rs1_val;
            end
            if (state_q == S_COMMIT) begin
                vl_q     <= new_vl;
                vill_q   <= chk_vill;
                fields_q <= chk_fields;
            end
        end
    end

    always_comb begin
        in_ready = 1'b0;
        rd_we    = 1'b0;
        done     = 1'b0;
        unique case (state_q)
            S_IDLE:   in_ready = 1'b1;
            S_COMMIT: ;
            S_WRBACK: begin
                rd_we = 1'b1;
                done  = 1'b1;
            end
            default: ;
        endcase
        rd_addr = rd_q;
        rd_data = XLEN'(vl_q);
        vl_o    = vl_q;
        vtype_o = {vill_q, {(XLEN-9){1'b0}}, fields_q};
        sew_o   = fields_q.sew;
        vill_o  = vill_q;
    end

    // R1: without an accept the configuration state holds
    a_r1_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (in_ready && !(in_valid && is_vcfg)) |=> ($stable(vl_o) && $stable(vtype_o) && in_ready));
    // R2: accept leads to done two edges later
    a_r2_accept_to_done: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> ##1 done);
    // R8: done is a single pulse and addresses the accepted rd
    a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && in_ready));
    a_r8_rd_addr: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($past(accept, 2) && (rd_addr == $past(instr[11:7], 2))));
    // R5: illegal configuration has zero length and cleared fields
    a_r5_vill_clears: assert property (@(posedge clk) disable iff (!rst_n)
        vill_o |-> ((vl_o == '0) && (vtype_o[XLEN-2:0] == '0)));
endmodule

// File: tb/vcfg_unit_bench.sv
module vcfg_unit_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [31:0] instr = '0;
    logic [4:0]  rs1_addr;
    logic [31:0] rs1_val = '0;
    logic        rd_we;
    logic [4:0]  rd_addr;
    logic [31:0] rd_data;
    logic        done;
    logic [7:0]  vl_o;
    logic [31:0] vtype_o;
    logic [2:0]  sew_o;
    logic        vill_o;

    int nchk = 0;
    int nfail = 0;

    always #10 clk = ~clk;

    vcfg_unit u_vcfg_unit (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .instr(instr), .rs1_addr(rs1_addr), .rs1_val(rs1_val), .rd_we(rd_we),
        .rd_addr(rd_addr), .rd_data(rd_data), .done(done), .vl_o(vl_o),
        .vtype_o(vtype_o), .sew_o(sew_o), .vill_o(vill_o)
    );

    // imm, avl, expected vl, expected vtype
    localparam int NV = 15;
    localparam logic [82:0] VEC [NV] = '{
        {11'h0C3, 32'd300,        8'd128, 32'h0000_00C3},
        {11'h0C3, 32'd100,        8'd100, 32'h0000_00C3},
        {11'h082, 32'd64,         8'd64,  32'h0000_0082},
        {11'h042, 32'd65,         8'd64,  32'h0000_0042},
        {11'h008, 32'd5,          8'd5,   32'h0000_0008},
        {11'h011, 32'hFFFF_FFFF,  8'd8,   32'h0000_0011},
        {11'h018, 32'd3,          8'd2,   32'h0000_0018},
        {11'h007, 32'd9,          8'd8,   32'h0000_0007},
        {11'h01F, 32'd4,          8'd1,   32'h0000_001F},
        {11'h01E, 32'd4,          8'd0,   32'h8000_0000},
        {11'h020, 32'd4,          8'd0,   32'h8000_0000},
        {11'h004, 32'd4,          8'd0,   32'h8000_0000},
        {11'h103, 32'd4,          8'd0,   32'h8000_0000},
        {11'h00B, 32'd0,          8'd0,   32'h0000_000B},
        {11'h013, 32'd32,         8'd32,  32'h0000_0013}
    };

    function automatic logic [31:0] mk(input logic [10:0] imm, input logic [4:0] rs1,
                                       input logic [4:0] rd);
        return {1'b0, imm, rs1, 3'b111, rd, 7'b1010111};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    // offers word w at the next negedge; returns after the done cycle is checked
    task automatic run_cfg(input logic [31:0] w, input logic [31:0] avl,
                           input logic [7:0] evl, input logic [31:0] evt, input bit busy_noise);
        @(negedge clk);
        in_valid = 1'b1; instr = w; rs1_val = avl;
        @(negedge clk);
        chk("R2 ready low in commit", {31'b0, in_ready}, 32'd0);
        chk("R2 no done in commit", {31'b0, done}, 32'd0);
        rs1_val = 32'd1;                          // R9: late AVL change ignored
        if (busy_noise) instr = mk(11'h004, 5'd3, 5'd30);
        else in_valid = 1'b0;
        @(negedge clk);
        chk("R2 done pulse", {31'b0, done}, 32'd1);
        chk("R8 rd_we with done", {31'b0, rd_we}, 32'd1);
        chk("R8 rd_addr", {27'b0, rd_addr}, {27'b0, w[11:7]});
        chk("R8 rd_data", rd_data, {24'b0, evl});
        chk("R4 vl", {24'b0, vl_o}, {24'b0, evl});
        chk("R3 R5 vtype", vtype_o, evt);
        chk("R7 sew", {29'b0, sew_o}, {29'b0, evt[5:3]});
        chk("R7 vill", {31'b0, vill_o}, {31'b0, evt[31]});
        in_valid = 1'b0;
        @(negedge clk);
        chk("R2 back to idle", {31'b0, in_ready}, 32'd1);
        chk("R8 single done", {31'b0, done}, 32'd0);
    endtask

    task automatic reject(input logic [31:0] w);
        logic [7:0]  pvl;
        logic [31:0] pvt;
        pvl = vl_o; pvt = vtype_o;
        @(negedge clk);
        in_valid = 1'b1; instr = w; rs1_val = 32'd7;
        @(negedge clk);
        in_valid = 1'b0;
        chk("R1 still ready", {31'b0, in_ready}, 32'd1);
        @(negedge clk);
        chk("R1 no done", {31'b0, done}, 32'd0);
        chk("R1 no rd_we", {31'b0, rd_we}, 32'd0);
        @(negedge clk);
        chk("R1 vl unchanged", {24'b0, vl_o}, {24'b0, pvl});
        chk("R1 vtype unchanged", vtype_o, pvt);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R6 reset vl", {24'b0, vl_o}, 32'd0);
        chk("R6 reset vtype", vtype_o, 32'h8000_0000);
        chk("R6 reset done", {31'b0, done}, 32'd0);
        chk("R6 reset rd_we", {31'b0, rd_we}, 32'd0);
        chk("R6 reset ready", {31'b0, in_ready}, 32'd1);
        rst_n = 1'b1;

        instr = mk(11'h0C3, 5'd21, 5'd4);
        #1 chk("R10 rs1_addr", {27'b0, rs1_addr}, 32'd21);

        for (int i = 0; i < NV; i++) begin
            run_cfg(mk(VEC[i][82:72], 5'(i), 5'(i + 1)), VEC[i][71:40],
                    VEC[i][39:32], VEC[i][31:0], 1'b0);
        end

        // R9: AVL 0 with legal vtype
        run_cfg(mk(11'h0C3, 5'd2, 5'd9), 32'd0, 8'd0, 32'h0000_00C3, 1'b0);
        // R2: word offered while busy is ignored
        run_cfg(mk(11'h082, 5'd2, 5'd17), 32'd40, 8'd40, 32'h0000_0082, 1'b1);
        // R1: non-matching words
        reject({1'b0, 11'h0C3, 5'd1, 3'b111, 5'd5, 7'b1010110});
        reject({1'b0, 11'h0C3, 5'd1, 3'b110, 5'd5, 7'b1010111});
        reject({1'b1, 11'h0C3, 5'd1, 3'b111, 5'd5, 7'b1010111});

        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        nchk++;
        nfail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end
endmodule